// File: doc/BRIEF.md
# SONET Transport Overhead Byte Inserter

This block sits in the transmit path of an STS-1 framer. It receives one byte per clock together with a pulse that marks the first byte of each frame. It follows the 9-row by 90-column frame with its own row and column counters. Inside the three transport overhead columns it rewrites each byte from one source. The possible sources are a parallel overhead port, a configuration register, an automatically generated value (parity, line RDI, line REI) or a fixed fill value. All other bytes pass through unchanged, and the output stream lags the input by exactly one clock.

Each overhead byte has its own fixed source priority. A register value beats the port, and the port beats the fill value. Both BIP-8 bytes (B1 over a whole frame, B2 over the line portion) are computed on the bytes actually sent and inserted one frame later. Each can be inverted. Line RDI and line REI come either from local receive-side inputs or from protection-board inputs. Each of these two source choices is sampled once per frame, at frame start, so a change never splits a frame.

Top module: `toh_oh_inserter`

## Requirements
- R1: Reset drives `out_byte` and `out_fs` to zero. After reset, every byte and its frame pulse appear on `out_byte`/`out_fs` one clock later. Payload bytes and the framing (row 1, columns 1–2) and pointer (row 4, columns 1–3) positions pass unchanged.
- R2: An order-wire, user or data-channel overhead position that selects neither a register nor the port is driven to all ones when `cfg_stuff_ones`=1, else to all zeros.
- R3: Port-eligible positions use `cfg_port_en` bit indices: E1 (row 2, col 2)=0; F1 (row 2, col 3)=1; D1–D3 (row 3)=2–4; D4–D12 (rows 6–8, in order)=5–13; S1 (row 9, col 1)=14; E2 (row 9, col 3)=15. When the position's enable bit and `ohp_vld` are both 1, the byte is `ohp_byte`. When the bit is set but `ohp_vld`=0, the fill value is used.
- R4: `cfg_reg_en` bit 0 puts `cfg_j0` at row 1, col 3; bit 1 puts `cfg_f1` at F1; bit 2 puts `cfg_s1` at S1. A register value overrides the port. With bit 0 clear, the row 1, col 3 byte passes unchanged.
- R5: Row 2, col 1 carries the XOR of all 810 output bytes of the previous frame, inverted when `cfg_b1_inv`=1. In the first frame after the first frame pulse the XOR value is zero.
- R6: Row 5, col 1 carries the XOR of the previous frame's output bytes, leaving out rows 1–3 of columns 1–3. It is inverted when `cfg_b2_inv`=1, and is zero in the first frame.
- R7: With `cfg_aps_all`=1, row 5 cols 2 and 3 are `cfg_k1` and `cfg_k2`. With it 0, row 5 col 2 and bits 7:3 of col 3 pass unchanged. Bits 2:0 of col 3 are 3'b110 when line RDI is active, else `cfg_k2[2:0]`.
- R8: Local line RDI is active when any bit of `rdi_def` is 1 with the matching `cfg_rdi_inh` bit 0.
- R9: `cfg_rdi_prot` and `cfg_rei_prot` are sampled on the frame-start byte and hold for the whole frame. When the sampled value is 1, line RDI is `prot_rdi` and the REI count is `prot_rei_cnt`.
- R10: Row 9, col 2 is the selected REI count, limited to 8 and zero-extended. When `cfg_rei_inh`=1 it is the fill value.
- R11: Before the first frame pulse after reset, every byte passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_fs | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Incoming stream byte |
| ohp_byte | input | 8 | Overhead port byte for the current position |
| ohp_vld | input | 1 | Overhead port byte is valid |
| cfg_stuff_ones | input | 1 | Fill value all ones (1) or all zeros (0) |
| cfg_port_en | input | 16 | Per-position port enables |
| cfg_reg_en | input | 3 | Register insertion enables for J0, F1, S1 |
| cfg_j0 | input | 8 | J0 register value |
| cfg_f1 | input | 8 | F1 register value |
| cfg_s1 | input | 8 | S1 register value |
| cfg_aps_all | input | 1 | Whole APS bytes from registers |
| cfg_k1 | input | 8 | K1 register value |
| cfg_k2 | input | 8 | K2 register value |
| rdi_def | input | 4 | Local RDI contributing defects |
| cfg_rdi_inh | input | 4 | Per-defect RDI inhibit |
| cfg_rdi_prot | input | 1 | Take line RDI from protection board |
| prot_rdi | input | 1 | Protection-board line RDI |
| rei_cnt | input | 4 | Local line error count |
| prot_rei_cnt | input | 4 | Protection-board line error count |
| cfg_rei_prot | input | 1 | Take REI count from protection board |
| cfg_rei_inh | input | 1 | Inhibit automatic REI insertion |
| cfg_b1_inv | input | 1 | Invert inserted B1 |
| cfg_b2_inv | input | 1 | Invert inserted B2 |
| out_fs | output | 1 | Frame-start marker, one clock late |
| out_byte | output | 8 | Modified stream byte |

## Verification
The assertions assume that `in_fs` arrives every 810 bytes with no stray pulses once framing starts. They also assume that a byte is presented on every clock and that the configuration and alarm inputs are quasi-static, so that the value seen at the K2 or M0 position is the one intended for that frame. The stimulus keeps a single position counter that raises the frame pulse only at index 0 and drives a byte on every falling edge. It changes configuration between bytes only. The source-select bits are the single exception: they are moved deliberately in mid-frame to show the frame-boundary sampling.

// File: rtl/toh_pkg.sv
package toh_pkg;

   localparam int BYTE_W  = 8;
   localparam int PORT_N  = 16;
   localparam int REG_N   = 3;
   localparam int REG_J0  = 0;
   localparam int REG_F1  = 1;
   localparam int REG_S1  = 2;
   localparam int IDX_F1  = 1;
   localparam int IDX_S1  = 14;

   typedef enum logic [3:0] {
      OH_PAYLOAD, OH_PASS, OH_J0, OH_B1, OH_B2,
      OH_K1, OH_K2, OH_M0, OH_PORT
   } oh_kind_e;

   // role of an overhead byte; row and col are zero-based, col < 3
   function automatic oh_kind_e oh_kind(input int row, input int col);
      oh_kind_e k;
      case (row)
         0:       k = (col == 2) ? OH_J0 : OH_PASS;
         1:       k = (col == 0) ? OH_B1 : OH_PORT;
         3:       k = OH_PASS;
         4:       k = (col == 0) ? OH_B2 : ((col == 1) ? OH_K1 : OH_K2);
         8:       k = (col == 1) ? OH_M0 : OH_PORT;
         default: k = OH_PORT;
      endcase
      return k;
   endfunction

   function automatic int oh_port_idx(input int row, input int col);
      int idx;
      case (row)
         1:       idx = col - 1;
         2:       idx = 2 + col;
         5, 6, 7: idx = 5 + (row - 5) * 3 + col;
         8:       idx = (col == 0) ? 14 : 15;
         default: idx = 0;
      endcase
      return idx;
   endfunction

endpackage

// File: rtl/toh_frame_pos.sv
module toh_frame_pos #(
   parameter int ROWS = 9,
   parameter int COLS = 90,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fs,
   output logic [RW-1:0] row,
   output logic [CW-1:0] col,
   output logic          synced
);

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;

   always_comb begin
      if (fs) begin
         row = '0;
         col = '0;
      end else if (col_q == CW'(COLS - 1)) begin
         col = '0;
         row = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end else begin
         col = col_q + 1'b1;
         row = row_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= RW'(ROWS - 1);
         col_q  <= CW'(COLS - 1);
         synced <= 1'b0;
      end else begin
         row_q <= row;
         col_q <= col;
         if (fs) synced <= 1'b1;
      end
   end

endmodule

// File: rtl/toh_bip8.sv
module toh_bip8 #(
   parameter int W         = 8,
   parameter int ROWS      = 9,
   parameter int COLS      = 90,
   parameter int TOH_COLS  = 3,
   parameter int SKIP_ROWS = 3,
   parameter bit LINE_ONLY = 1'b0,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          fs,
   input  logic [RW-1:0] row,
   input  logic [CW-1:0] col,
   input  logic [W-1:0]  data,
   output logic [W-1:0]  bip_q
);

   logic          covered;
   logic [W-1:0]  acc_q;
   logic [W-1:0]  term;

   generate
      if (LINE_ONLY) begin : g_line
         assign covered = !((row < RW'(SKIP_ROWS)) && (col < CW'(TOH_COLS)));
      end else begin : g_frame
         assign covered = 1'b1;
      end
   endgenerate

   assign term = covered ? data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         bip_q <= '0;
      end else if (fs) begin
         bip_q <= acc_q;
         acc_q <= term;
      end else if (en) begin
         acc_q <= acc_q ^ term;
      end
   end

endmodule

// File: rtl/toh_byte_mux.sv
module toh_byte_mux
   import toh_pkg::*;
#(
   parameter int W = 8
) (
   input  oh_kind_e            kind,
   input  logic [3:0]          port_idx,
   input  logic [W-1:0]        in_byte,
   input  logic [W-1:0]        ohp_byte,
   input  logic                ohp_vld,
   input  logic [W-1:0]        stuff,
   input  logic [PORT_N-1:0]   port_en,
   input  logic [REG_N-1:0]    reg_en,
   input  logic [W-1:0]        reg_j0,
   input  logic [W-1:0]        reg_f1,
   input  logic [W-1:0]        reg_s1,
   input  logic                aps_all,
   input  logic [W-1:0]        reg_k1,
   input  logic [W-1:0]        reg_k2,
   input  logic                rdi,
   input  logic                rei_inh,
   input  logic [W-1:0]        rei_byte,
   input  logic [W-1:0]        b1,
   input  logic [W-1:0]        b2,
   output logic [W-1:0]        out_byte
);

   always_comb begin
      unique case (kind)
         OH_J0:   out_byte = reg_en[REG_J0] ? reg_j0 : in_byte;
         OH_B1:   out_byte = b1;
         OH_B2:   out_byte = b2;
         OH_K1:   out_byte = aps_all ? reg_k1 : in_byte;
         OH_K2:   out_byte = aps_all ? reg_k2 :
                             {in_byte[W-1:3], (rdi ? 3'b110 : reg_k2[2:0])};
         OH_M0:   out_byte = rei_inh ? stuff : rei_byte;
         OH_PORT: begin
            if (reg_en[REG_F1] && port_idx == 4'(IDX_F1))
               out_byte = reg_f1;
            else if (reg_en[REG_S1] && port_idx == 4'(IDX_S1))
               out_byte = reg_s1;
            else if (port_en[port_idx] && ohp_vld)
               out_byte = ohp_byte;
            else
               out_byte = stuff;
         end
         default: out_byte = in_byte;
      endcase
   end

endmodule

// File: rtl/toh_oh_inserter.sv
module toh_oh_inserter
   import toh_pkg::*;
#(
   parameter int ROWS     = 9,
   parameter int COLS     = 90,
   parameter int TOH_COLS = 3,
   parameter int NDEF     = 4,
   parameter int ERRW     = 4,
   parameter int REI_MAX  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_fs,
   input  logic [7:0]          in_byte,
   input  logic [7:0]          ohp_byte,
   input  logic                ohp_vld,
   input  logic                cfg_stuff_ones,
   input  logic [15:0]         cfg_port_en,
   input  logic [2:0]          cfg_reg_en,
   input  logic [7:0]          cfg_j0,
   input  logic [7:0]          cfg_f1,
   input  logic [7:0]          cfg_s1,
   input  logic                cfg_aps_all,
   input  logic [7:0]          cfg_k1,
   input  logic [7:0]          cfg_k2,
   input  logic [NDEF-1:0]     rdi_def,
   input  logic [NDEF-1:0]     cfg_rdi_inh,
   input  logic                cfg_rdi_prot,
   input  logic                prot_rdi,
   input  logic [ERRW-1:0]     rei_cnt,
   input  logic [ERRW-1:0]     prot_rei_cnt,
   input  logic                cfg_rei_prot,
   input  logic                cfg_rei_inh,
   input  logic                cfg_b1_inv,
   input  logic                cfg_b2_inv,
   output logic                out_fs,
   output logic [7:0]          out_byte
);

   localparam int W  = BYTE_W;
   localparam int RW = $clog2(ROWS);
   localparam int CW = $clog2(COLS);

   generate
      if (ROWS != 9 || TOH_COLS != 3) begin : g_bad_shape
         $error("overhead layout needs 9 rows and 3 overhead columns");
      end
      if (COLS <= TOH_COLS) begin : g_bad_cols
         $error("frame must have payload columns");
      end
      if (ERRW < 4 || ERRW > W) begin : g_bad_errw
         $error("error count width out of range");
      end
   endgenerate

   logic [RW-1:0] row;
   logic [CW-1:0] col;
   logic          synced_q;
   oh_kind_e      kind;
   logic [3:0]    port_idx;
   logic          rdi_sel_q, rei_sel_q;
   logic          rdi_local, rdi_now;
   logic [ERRW-1:0] rei_raw, rei_capped;
   logic [W-1:0]  b1_q, b2_q, stuff, mux_byte, out_nx;

   toh_frame_pos #(.ROWS(ROWS), .COLS(COLS)) u_pos (
      .clk(clk), .rst_n(rst_n), .fs(in_fs),
      .row(row), .col(col), .synced(synced_q)
   );

   always_comb begin
      if (col < CW'(TOH_COLS)) begin
         kind     = oh_kind(int'(row), int'(col));
         port_idx = 4'(oh_port_idx(int'(row), int'(col)));
      end else begin
         kind     = OH_PAYLOAD;
         port_idx = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdi_sel_q <= 1'b0;
         rei_sel_q <= 1'b0;
      end else if (in_fs) begin
         rdi_sel_q <= cfg_rdi_prot;
         rei_sel_q <= cfg_rei_prot;
      end
   end

   assign rdi_local  = |(rdi_def & ~cfg_rdi_inh);
   assign rdi_now    = rdi_sel_q ? prot_rdi : rdi_local;
   assign rei_raw    = rei_sel_q ? prot_rei_cnt : rei_cnt;
   assign rei_capped = (rei_raw > ERRW'(REI_MAX)) ? ERRW'(REI_MAX) : rei_raw;
   assign stuff      = {W{cfg_stuff_ones}};

   toh_byte_mux #(.W(W)) u_mux (
      .kind(kind), .port_idx(port_idx), .in_byte(in_byte),
      .ohp_byte(ohp_byte), .ohp_vld(ohp_vld), .stuff(stuff),
      .port_en(cfg_port_en), .reg_en(cfg_reg_en),
      .reg_j0(cfg_j0), .reg_f1(cfg_f1), .reg_s1(cfg_s1),
      .aps_all(cfg_aps_all), .reg_k1(cfg_k1), .reg_k2(cfg_k2),
      .rdi(rdi_now), .rei_inh(cfg_rei_inh), .rei_byte(W'(rei_capped)),
      .b1(b1_q ^ {W{cfg_b1_inv}}), .b2(b2_q ^ {W{cfg_b2_inv}}),
      .out_byte(mux_byte)
   );

   assign out_nx = (synced_q || in_fs) ? mux_byte : in_byte;

   toh_bip8 #(.W(W), .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS),
              .SKIP_ROWS(3), .LINE_ONLY(1'b0)) u_b1 (
      .clk(clk), .rst_n(rst_n), .en(synced_q), .fs(in_fs),
      .row(row), .col(col), .data(out_nx), .bip_q(b1_q)
   );

   toh_bip8 #(.W(W), .ROWS(ROWS), .COLS(COLS), .TOH_COLS(TOH_COLS),
              .SKIP_ROWS(3), .LINE_ONLY(1'b1)) u_b2 (
      .clk(clk), .rst_n(rst_n), .en(synced_q), .fs(in_fs),
      .row(row), .col(col), .data(out_nx), .bip_q(b2_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_byte <= '0;
         out_fs   <= 1'b0;
      end else begin
         out_byte <= out_nx;
         out_fs   <= in_fs;
      end
   end

endmodule

// File: rtl/toh_oh_inserter_chk.sv
module toh_oh_inserter_chk
   import toh_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       in_fs,
   input logic [7:0] in_byte,
   input logic       out_fs,
   input logic [7:0] out_byte,
   input oh_kind_e   kind,
   input logic       synced_q,
   input logic       rdi_sel_q,
   input logic       rei_sel_q,
   input logic       cfg_rdi_prot,
   input logic       cfg_rei_prot,
   input logic       rdi_now,
   input logic       cfg_aps_all,
   input logic       cfg_rei_inh
);

   // R1
   frame_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_fs |=> out_fs);

   // R1
   payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (synced_q && kind == OH_PAYLOAD) |=> out_byte == $past(in_byte));

   // R11
   presync_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!synced_q && !in_fs) |=> out_byte == $past(in_byte));

   // R9
   rdi_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_fs |=> $stable(rdi_sel_q) && $stable(rei_sel_q));

   // R9
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_fs |=> (rdi_sel_q == $past(cfg_rdi_prot)) && (rei_sel_q == $past(cfg_rei_prot)));

   // R7
   k2_rdi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (synced_q && kind == OH_K2 && !cfg_aps_all && rdi_now) |=> out_byte[2:0] == 3'b110);

   // R10
   rei_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (synced_q && kind == OH_M0 && !cfg_rei_inh) |=> out_byte <= 8'd8);

endmodule

bind toh_oh_inserter toh_oh_inserter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_fs(in_fs), .in_byte(in_byte),
   .out_fs(out_fs), .out_byte(out_byte), .kind(kind), .synced_q(synced_q),
   .rdi_sel_q(rdi_sel_q), .rei_sel_q(rei_sel_q),
   .cfg_rdi_prot(cfg_rdi_prot), .cfg_rei_prot(cfg_rei_prot),
   .rdi_now(rdi_now), .cfg_aps_all(cfg_aps_all), .cfg_rei_inh(cfg_rei_inh)
);

// File: tb/toh_oh_inserter_tb.sv
`timescale 1ns/1ps
module toh_oh_inserter_tb_top;

   localparam int FRAME = 810;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_fs = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [7:0]  ohp_byte = '0;
   logic        ohp_vld = 1'b0;
   logic        cfg_stuff_ones = 1'b1;
   logic [15:0] cfg_port_en = '0;
   logic [2:0]  cfg_reg_en = '0;
   logic [7:0]  cfg_j0 = 8'h4A, cfg_f1 = 8'h1F, cfg_s1 = 8'h0F;
   logic        cfg_aps_all = 1'b0;
   logic [7:0]  cfg_k1 = 8'h3C, cfg_k2 = 8'hA5;
   logic [3:0]  rdi_def = '0, cfg_rdi_inh = '0;
   logic        cfg_rdi_prot = 1'b0, prot_rdi = 1'b0;
   logic [3:0]  rei_cnt = '0, prot_rei_cnt = '0;
   logic        cfg_rei_prot = 1'b0, cfg_rei_inh = 1'b0;
   logic        cfg_b1_inv = 1'b0, cfg_b2_inv = 1'b0;
   logic        out_fs;
   logic [7:0]  out_byte;

   toh_oh_inserter dut_i (
      .clk(clk), .rst_n(rst_n), .in_fs(in_fs), .in_byte(in_byte),
      .ohp_byte(ohp_byte), .ohp_vld(ohp_vld), .cfg_stuff_ones(cfg_stuff_ones),
      .cfg_port_en(cfg_port_en), .cfg_reg_en(cfg_reg_en),
      .cfg_j0(cfg_j0), .cfg_f1(cfg_f1), .cfg_s1(cfg_s1),
      .cfg_aps_all(cfg_aps_all), .cfg_k1(cfg_k1), .cfg_k2(cfg_k2),
      .rdi_def(rdi_def), .cfg_rdi_inh(cfg_rdi_inh),
      .cfg_rdi_prot(cfg_rdi_prot), .prot_rdi(prot_rdi),
      .rei_cnt(rei_cnt), .prot_rei_cnt(prot_rei_cnt),
      .cfg_rei_prot(cfg_rei_prot), .cfg_rei_inh(cfg_rei_inh),
      .cfg_b1_inv(cfg_b1_inv), .cfg_b2_inv(cfg_b2_inv),
      .out_fs(out_fs), .out_byte(out_byte)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int drv_i = 0;
   int seed = 0;
   logic last_out_fs;
   logic [7:0] last_out;
   logic [7:0] cap [0:FRAME-1];
   logic [7:0] acc1 = '0, acc2 = '0, prev_b1 = '0, prev_b2 = '0;
   int  mon_idx = 0;
   bit  mon_seen = 0;
   bit  done = 0;

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 13 + seed) & 255);
   endfunction

   function automatic logic [7:0] opat(input int i);
      return 8'(i & 255) ^ 8'h5A;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // output monitor: captures the current frame and its bench BIP values
   always @(negedge clk) begin
      if (!rst_n) begin
         mon_seen = 0; acc1 = '0; acc2 = '0; prev_b1 = '0; prev_b2 = '0;
      end else if (out_fs) begin
         prev_b1 = acc1; prev_b2 = acc2;
         acc1 = out_byte; acc2 = '0;
         mon_idx = 0; cap[0] = out_byte; mon_seen = 1;
      end else if (mon_seen) begin
         mon_idx++;
         if (mon_idx < FRAME) begin
            cap[mon_idx] = out_byte;
            acc1 ^= out_byte;
            if (!((mon_idx / 90) < 3 && (mon_idx % 90) < 3)) acc2 ^= out_byte;
         end
      end
   end

   task automatic drive_byte();
      @(negedge clk);
      last_out_fs = out_fs;
      last_out    = out_byte;
      in_fs    = (drv_i == 0);
      in_byte  = pat(drv_i);
      ohp_byte = opat(drv_i);
      drv_i    = (drv_i == FRAME - 1) ? 0 : drv_i + 1;
   endtask

   task automatic run_frame();
      repeat (FRAME) drive_byte();
   endtask

   task automatic t_reset();
      chk("R1 reset out_byte", out_byte, 8'h00);
      chk("R1 reset out_fs", {7'd0, out_fs}, 8'h00);
   endtask

   task automatic t_presync();
      logic [7:0] prev;
      drv_i = 400;
      drive_byte();
      for (int k = 0; k < 4; k++) begin
         prev = in_byte;
         drive_byte();
         chk("R11 pass before framing", last_out, prev);
      end
   endtask

   task automatic t_first_frame();
      seed = 3;
      drv_i = 0;
      drive_byte();
      drive_byte();
      chk("R1 out_fs delayed", {7'd0, last_out_fs}, 8'h01);
      drive_byte();
      chk("R1 out_fs single", {7'd0, last_out_fs}, 8'h00);
      repeat (FRAME - 3) drive_byte();
      chk("R1 A1 pass", cap[0], pat(0));
      chk("R1 H1 pass", cap[270], pat(270));
      chk("R1 payload pass", cap[455], pat(455));
      chk("R4 J0 pass when off", cap[2], pat(2));
      chk("R5 B1 first frame", cap[90], 8'h00);
      chk("R6 B2 first frame", cap[360], 8'h00);
      chk("R2 E1 fill ones", cap[91], 8'hFF);
      chk("R2 E2 fill ones", cap[722], 8'hFF);
   endtask

   task automatic t_bip_fill();
      seed = 77; cfg_stuff_ones = 1'b0; cfg_b1_inv = 1'b1; cfg_b2_inv = 1'b1;
      run_frame();
      chk("R5 B1 inverted", cap[90], prev_b1 ^ 8'hFF);
      chk("R6 B2 inverted", cap[360], prev_b2 ^ 8'hFF);
      chk("R2 D2 fill zeros", cap[181], 8'h00);
      seed = 140; cfg_b1_inv = 1'b0; cfg_b2_inv = 1'b0;
      run_frame();
      chk("R5 B1 plain", cap[90], prev_b1);
      chk("R6 B2 plain", cap[360], prev_b2);
      run_frame();
      chk("R5 B1 next frame", cap[90], prev_b1);
      chk("R6 B2 next frame", cap[360], prev_b2);
   endtask

   task automatic t_port_reg();
      cfg_stuff_ones = 1'b1; cfg_port_en = 16'hFFFF; ohp_vld = 1'b1;
      run_frame();
      chk("R3 E1 port", cap[91], opat(91));
      chk("R3 F1 port", cap[92], opat(92));
      chk("R3 D4 port", cap[450], opat(450));
      chk("R3 D12 port", cap[632], opat(632));
      chk("R3 E2 port", cap[722], opat(722));
      cfg_reg_en = 3'b111;
      run_frame();
      chk("R4 J0 register", cap[2], cfg_j0);
      chk("R4 F1 register over port", cap[92], cfg_f1);
      chk("R4 S1 register over port", cap[720], cfg_s1);
      chk("R3 E1 port beside registers", cap[91], opat(91));
      cfg_reg_en = 3'b000; ohp_vld = 1'b0;
      run_frame();
      chk("R3 E1 invalid port fill", cap[91], 8'hFF);
      chk("R3 D1 invalid port fill", cap[180], 8'hFF);
      cfg_port_en = 16'h8000; ohp_vld = 1'b1;
      run_frame();
      chk("R3 E2 bit 15", cap[722], opat(722));
      chk("R3 E1 disabled fill", cap[91], 8'hFF);
      chk("R3 S1 disabled fill", cap[720], 8'hFF);
      cfg_port_en = '0; ohp_vld = 1'b0;
   endtask

   task automatic t_aps();
      seed = 9; cfg_aps_all = 1'b1;
      run_frame();
      chk("R7 K1 register", cap[361], cfg_k1);
      chk("R7 K2 register", cap[362], cfg_k2);
      cfg_aps_all = 1'b0; rdi_def = 4'b0001; cfg_rdi_inh = 4'b0001;
      run_frame();
      chk("R7 K1 pass", cap[361], pat(361));
      chk("R8 inhibited defect", cap[362], {pat(362)[7:3], 3'b101});
      rdi_def = 4'b0011;
      run_frame();
      chk("R8 active defect RDI", cap[362], {pat(362)[7:3], 3'b110});
      rdi_def = 4'b0000;
      run_frame();
      chk("R7 K2 low from register", cap[362], {pat(362)[7:3], 3'b101});
   endtask

   task automatic t_select();
      seed = 21; prot_rdi = 1'b1; rei_cnt = 4'd3; prot_rei_cnt = 4'd12;
      cfg_rdi_prot = 1'b0; cfg_rei_prot = 1'b0;
      repeat (100) drive_byte();
      cfg_rdi_prot = 1'b1; cfg_rei_prot = 1'b1;
      repeat (FRAME - 100) drive_byte();
      chk("R9 RDI select held in frame", cap[362], {pat(362)[7:3], 3'b101});
      chk("R9 REI select held in frame", cap[721], 8'd3);
      run_frame();
      chk("R9 RDI from protection", cap[362], {pat(362)[7:3], 3'b110});
      chk("R10 protection REI limited", cap[721], 8'd8);
      cfg_rdi_prot = 1'b0; cfg_rei_prot = 1'b0; prot_rdi = 1'b0;
      run_frame();
      chk("R9 back to local REI", cap[721], 8'd3);
   endtask

   task automatic t_rei();
      rei_cnt = 4'd15;
      run_frame();
      chk("R10 REI 15 limited", cap[721], 8'd8);
      rei_cnt = 4'd7;
      run_frame();
      chk("R10 REI 7", cap[721], 8'd7);
      cfg_rei_inh = 1'b1;
      run_frame();
      chk("R10 REI inhibited fill", cap[721], 8'hFF);
      cfg_rei_inh = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_presync();
      t_first_frame();
      t_bip_fill();
      t_port_reg();
      t_aps();
      t_select();
      t_rei();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule